// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and checks the even parity bit of a 32-bit PCI bus. It watches the multiplexed address/data lines, the command/byte-enable lines and the bus handshake (FRAME#, IRDY#, TRDY#). From the handshake it works out the address phase and each data phase. It knows whether the local agent owns the transfer as initiator and whether the transfer reads or writes. From that it decides, clock by clock, whether it drives PAR or checks the PAR that the other agent drives.

Parity is never combinational to the pins. The bus value of a covered clock is folded into one bit and registered, so PAR appears one clock after the bits it covers. A received PAR is compared one clock later still, and a mismatch gives a one-clock error pulse. Address errors and data errors have separate pulses. Error reporting policy and the pad tristate are left to the surrounding logic, which uses `par_oe_o` to enable the PAR pad.

Top module: `pci_par_unit`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `par_oe_o`, `par_o`, `addr_perr_o` and `data_perr_o` are all 0.
- R2: On the clock after any clock on which the block drives parity, `par_o` equals the XOR of all 32 bits of `ad_i` and all 4 bits of `cbe_n_i` sampled on that clock. The 37 bits together then hold an even number of ones.
- R3: An address phase is a clock with `frame_n_i` low while the bus is idle. If `local_master_i` is 1 on that clock, `par_oe_o` is 1 on the next clock and `par_o` carries the address parity.
- R4: `cbe_n_i[0]` sampled in the address phase selects the direction: 1 means write, 0 means read. As initiator of a write, the block drives parity for every data clock with `irdy_n_i` low. It keeps `par_oe_o` high through target wait states.
- R5: As target of a read, the block drives parity for every data clock with `trdy_n_i` low. `par_oe_o` first rises on the clock after the first such clock.
- R6: While `par_oe_o` stays high, `par_o` keeps its value across clocks on which no new parity is generated.
- R7: `par_oe_o` is high on the clock after the final data phase completes (`frame_n_i` high, `irdy_n_i` and `trdy_n_i` low) and low on the clock after that. As initiator of a read, it is high only on the single clock after the address phase.
- R8: When `local_master_i` is 0 in an address phase, `par_i` on the next clock is compared with the address parity. A mismatch sets `addr_perr_o` for exactly one clock, two clocks after the address phase.
- R9: For data phases the block does not drive, only completed clocks (`irdy_n_i` and `trdy_n_i` both low) are checked. `data_perr_o` pulses for one clock, two clocks later, if `par_i` on the following clock mismatches. Wait clocks are never checked.
- R10: Each single-bit error on `ad_i`, `cbe_n_i` or `par_i` in a checked clock gives exactly one error pulse. Errors in clocks the block drives itself, and errors in unchecked clocks, give none.
- R11: While a transaction is in progress, `frame_n_i` held low is not taken as a new address phase. A new address phase is recognised only after the final data phase has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command / byte-enable lines (active-low enables) |
| frame_n_i | input | 1 | Transaction framing, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| par_i | input | 1 | Parity bit as seen on the bus |
| local_master_i | input | 1 | 1 when the local agent initiates the transaction starting now |
| par_o | output | 1 | Registered parity to drive |
| par_oe_o | output | 1 | Enable for driving `par_o` onto the bus |
| addr_perr_o | output | 1 | One-clock pulse: address parity mismatch |
| data_perr_o | output | 1 | One-clock pulse: data parity mismatch |

## Verification
Transactions are run in all four combinations of initiator/target role and read/write direction. Each combination separates a different owner of PAR, so a wrong ownership decision shows as a misplaced enable or a missing or spurious error pulse. Wait clocks are placed inside bursts with the target stalling. In writes, these show whether parity is taken from the ready clock or from the completing clock. In reads, a corrupted PAR placed right after a wait tells a checker that counts only completed phases apart from one that counts every clock. Single-bit flips on an address line, a byte-enable line and the PAR line each land in address phases, in received data phases and in self-driven phases. This separates the right pulse on the right clock from a pulse on the wrong flag, a pulse at the wrong delay, or a pulse where none belongs.

// File: rtl/pci_par_unit.sv
module pci_par_unit #(
  parameter int ADW = 32,
  parameter int BEW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ADW-1:0] ad_i,
  input  logic [BEW-1:0] cbe_n_i,
  input  logic           frame_n_i,
  input  logic           irdy_n_i,
  input  logic           trdy_n_i,
  input  logic           par_i,
  input  logic           local_master_i,
  output logic           par_o,
  output logic           par_oe_o,
  output logic           addr_perr_o,
  output logic           data_perr_o
);

  logic idle_q, role_q, wr_q, par_q, oe_q, sum_q, chk_a_q, chk_d_q, ap_q, dp_q;

  wire bus_par = ^{ad_i, cbe_n_i};
  wire addr_ph = idle_q & ~frame_n_i;
  wire in_data = ~idle_q;
  wire done    = in_data & ~irdy_n_i & ~trdy_n_i;
  wire last    = done & frame_n_i;
  wire rdy     = wr_q ? ~irdy_n_i : ~trdy_n_i;
  wire own     = (role_q == wr_q);
  wire gen     = (addr_ph & local_master_i) | (in_data & own & rdy);
  wire keep    = oe_q & in_data & own & ~last;
  wire chk_a   = addr_ph & ~local_master_i;
  wire chk_d   = done & ~own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b1;
      role_q  <= 1'b0;
      wr_q    <= 1'b0;
      par_q   <= 1'b0;
      oe_q    <= 1'b0;
      sum_q   <= 1'b0;
      chk_a_q <= 1'b0;
      chk_d_q <= 1'b0;
      ap_q    <= 1'b0;
      dp_q    <= 1'b0;
    end else begin
      if (addr_ph) begin
        idle_q <= 1'b0;
        role_q <= local_master_i;
        wr_q   <= cbe_n_i[0];
      end else if (last) begin
        idle_q <= 1'b1;
      end
      if (gen) par_q <= bus_par;
      oe_q    <= gen | keep;
      sum_q   <= bus_par;
      chk_a_q <= chk_a;
      chk_d_q <= chk_d;
      ap_q    <= chk_a_q & (par_i != sum_q);
      dp_q    <= chk_d_q & (par_i != sum_q);
    end
  end

  assign par_o       = par_q;
  assign par_oe_o    = oe_q;
  assign addr_perr_o = ap_q;
  assign data_perr_o = dp_q;

endmodule

// File: rtl/pci_par_unit_chk.sv
module pci_par_unit_chk #(
  parameter int ADW = 32,
  parameter int BEW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [ADW-1:0] ad_i,
  input logic [BEW-1:0] cbe_n_i,
  input logic           frame_n_i,
  input logic           irdy_n_i,
  input logic           trdy_n_i,
  input logic           local_master_i,
  input logic           par_o,
  input logic           par_oe_o,
  input logic           addr_perr_o,
  input logic           data_perr_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!par_oe_o && !addr_perr_o && !data_perr_o));

  assert_first_par_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_oe_o) |-> (par_o == $past(^{ad_i, cbe_n_i})));

  assert_master_addr_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_n_i) && !frame_n_i && local_master_i) |=> par_oe_o);

  assert_idle_releases_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_n_i && irdy_n_i) |-> !par_oe_o);

  assert_data_err_completed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_perr_o |-> $past(!irdy_n_i && !trdy_n_i, 2));

  assert_addr_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_perr_o |=> !addr_perr_o);

endmodule

bind pci_par_unit pci_par_unit_chk #(.ADW(ADW), .BEW(BEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
  .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
  .local_master_i(local_master_i), .par_o(par_o), .par_oe_o(par_oe_o),
  .addr_perr_o(addr_perr_o), .data_perr_o(data_perr_o)
);

// File: tb/sim_pci_par_unit.sv
`timescale 1ns/1ps
module sim_pci_par_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [31:0] ad_i;
  logic [3:0]  cbe_n_i;
  logic        frame_n_i, irdy_n_i, trdy_n_i, par_i, local_master_i;
  logic        par_o, par_oe_o, addr_perr_o, data_perr_o;

  pci_par_unit u0 (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
    .par_i(par_i), .local_master_i(local_master_i), .par_o(par_o),
    .par_oe_o(par_oe_o), .addr_perr_o(addr_perr_o), .data_perr_o(data_perr_o)
  );

  localparam int NB = 4096;
  int vectors = 0, miscompares = 0, k = 0;
  bit e_oe[NB], e_par[NB], e_ap[NB], e_dp[NB];
  bit m_g, w_g, pend_inj, prev_good, prev_act, prev_ca, prev_cd, finished;
  int exp_pulses = 0, seen_pulses = 0;

  task automatic chk1(input string req, input logic got, input bit exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %b exp %b", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // kind: 0 idle, 1 address phase, 2 data clock
  task automatic beat(input int kind, input logic [31:0] a, input logic [3:0] c,
                      input logic fr, input logic ir, input logic tr,
                      input logic [31:0] fa, input logic [3:0] fc, input string tag);
    bit own, rdy, dn;
    @(negedge clk);
    chk1({tag, " R7 par_oe_o"}, par_oe_o, e_oe[k]);
    if (e_oe[k]) chk1({tag, " R2/R6 par_o"}, par_o, e_par[k]);
    chk1({tag, " R8 addr_perr_o"}, addr_perr_o, e_ap[k]);
    chk1({tag, " R9 data_perr_o"}, data_perr_o, e_dp[k]);
    seen_pulses += int'(addr_perr_o) + int'(data_perr_o);
    exp_pulses  += int'(e_ap[k]) + int'(e_dp[k]);
    ad_i = a ^ fa; cbe_n_i = c ^ fc;
    frame_n_i = fr; irdy_n_i = ir; trdy_n_i = tr;
    local_master_i = m_g;
    par_i = prev_good ^ pend_inj;
    pend_inj = 0;
    if (prev_ca) e_ap[k+2-1] = (par_i != prev_act);
    if (prev_cd) e_dp[k+1]   = (par_i != prev_act);
    prev_good = ^{a, c};
    prev_act  = ^{a ^ fa, c ^ fc};
    prev_ca = 0; prev_cd = 0;
    e_par[k+1] = e_par[k];
    own = (m_g == w_g);
    if (kind == 1) begin
      if (m_g) begin e_oe[k+1] = 1; e_par[k+1] = prev_act; end
      else prev_ca = 1;
    end else if (kind == 2) begin
      rdy = w_g ? !ir : !tr;
      dn  = !ir && !tr;
      if (own && rdy) begin e_oe[k+1] = 1; e_par[k+1] = prev_act; end
      if (own && e_oe[k] && !(dn && fr)) e_oe[k+1] = 1;
      if (!own && dn) prev_cd = 1;
    end
    k++;
  endtask

  // ikind: 0 none, 1 PAR flip after clock iat, 2 AD bit flip, 3 C/BE# bit flip,
  //        4 PAR flip right after the wait clock
  task automatic txn(input bit m, input bit w, input int n, input int wait_at,
                     input int ikind, input int iat, input string tag);
    logic [31:0] a, fa;
    logic [3:0]  c, fc;
    m_g = m; w_g = w;
    a = $urandom; c = w ? 4'b0111 : 4'b0110;
    fa = (ikind == 2 && iat == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
    fc = (ikind == 3 && iat == 0) ? (4'h1 << ($urandom % 3 + 1)) : 4'h0;
    beat(1, a, c, 1'b0, 1'b1, 1'b1, fa, fc, tag);
    if (ikind == 1 && iat == 0) pend_inj = 1;
    for (int i = 1; i <= n; i++) begin
      a = $urandom; c = 4'($urandom);
      if (i == wait_at) begin
        beat(2, a, c, i == n, 1'b0, 1'b1, 32'h0, 4'h0, tag);
        if (ikind == 4) pend_inj = 1;
      end
      fa = (ikind == 2 && iat == i) ? (32'h1 << ($urandom % 32)) : 32'h0;
      fc = (ikind == 3 && iat == i) ? (4'h1 << ($urandom % 4)) : 4'h0;
      beat(2, a, c, i == n, 1'b0, 1'b0, fa, fc, tag);
      if (ikind == 1 && iat == i) pend_inj = 1;
    end
    beat(0, $urandom, 4'($urandom), 1'b1, 1'b1, 1'b1, 32'h0, 4'h0, tag);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; ad_i = 0; cbe_n_i = 4'hF; frame_n_i = 1; irdy_n_i = 1; trdy_n_i = 1;
    par_i = 0; local_master_i = 0;
    repeat (3) @(negedge clk);
    chk1("R1 par_oe_o in reset", par_oe_o, 0);
    chk1("R1 par_o in reset", par_o, 0);
    chk1("R1 addr_perr_o in reset", addr_perr_o, 0);
    chk1("R1 data_perr_o in reset", data_perr_o, 0);
    rst_n = 1;
    txn(1, 0, 1, 0, 0, 0, "R3 master read");
    txn(1, 1, 4, 2, 0, 0, "R4 master write");
    txn(0, 0, 3, 2, 0, 0, "R5 target read");
    txn(1, 1, 5, 3, 0, 0, "R6 write hold");
    txn(0, 1, 4, 0, 0, 0, "R8 clean addr");
    txn(0, 1, 3, 0, 1, 0, "R8 par flip addr");
    txn(0, 0, 2, 0, 2, 0, "R10 ad flip addr");
    txn(1, 0, 4, 0, 1, 2, "R9 par flip data");
    txn(0, 1, 4, 0, 3, 3, "R9 cbe flip data");
    txn(0, 1, 6, 3, 4, 0, "R11 wait then flip");
    txn(1, 0, 3, 2, 4, 0, "R9 wait ignored");
    txn(1, 1, 3, 0, 1, 1, "R10 own phase flip");
    txn(1, 0, 3, 0, 2, 0, "R10 own addr flip");
    for (int t = 0; t < 60; t++)
      txn(1'($urandom), 1'($urandom), 1 + $urandom % 5, $urandom % 4,
          $urandom % 5, $urandom % 4, "R2 mixed");
    m_g = 0; w_g = 0;
    repeat (3) beat(0, 32'h0, 4'hF, 1'b1, 1'b1, 1'b1, 32'h0, 4'h0, "R7 drain");
    chk1("R10 error pulse total", (seen_pulses == exp_pulses), 1'b1);
    if (seen_pulses != exp_pulses)
      $display("  R10 pulses seen %0d expected %0d", seen_pulses, exp_pulses);
    summary();
  end
endmodule